// File: doc/BRIEF.md
# Time-Division Bearer and Signalling Channel Packer

This block sits on a frame-synchronised serial line that carries, in every frame, two 8-bit bearer channels followed by a 2-bit signalling channel. The line is timed by a data clock, which is presented here as a one-cycle enable pulse in the system clock domain, and a frame sync pulse that marks the first bearer bit of each frame. The block assembles the bytes of four consecutive frames into one 32-bit receive word for each bearer channel. It gathers the signalling bits of the same four frames into one 8-bit word. In the other direction, it serialises one 32-bit transmit word per bearer channel back onto the line over four frames.

Each channel has its own mode input that selects plain data or HDLC-encoded data. The mode fixes the order of bits within a byte: plain data travels most significant bit first, and HDLC data least significant bit first. In both modes, the earliest frame of a group lands in the top byte of the word. A ready pulse is raised when a receive word is complete, and a load pulse marks the moment the transmit words are captured. Framing, flag hunting and any register access belong to logic outside this block.

Top module: `tdm_bd_packer`

## Requirements
- R1: After reset every receive word and the signalling word read zero, all ready pulses and the load pulse are low, and the transmit line rests at 1.
- R2: The line bit that comes with frame sync is bit 0 of bearer channel 1. Bits 0 to 7 after sync belong to channel 1, bits 8 to 15 to channel 2, and bits 16 and 17 to the signalling channel. Any further bits before the next sync are ignored.
- R3: In plain mode (mode input 0) the first line bit of a frame's byte is stored in bit 7 of that byte, and the last in bit 0.
- R4: In HDLC mode (mode input 1) the first line bit of a frame's byte is stored in bit 0 of that byte, and the last in bit 7.
- R5: The byte of the first frame of a four-frame group occupies bits 31:24 of the receive word, and the byte of the fourth frame occupies bits 7:0, in either mode.
- R6: The ready pulse of a bearer channel is high for exactly one clock cycle, in the cycle after the data-clock enable that carried the last bit of the fourth frame's byte. The receive word changes only together with that pulse and is held between groups.
- R7: The signalling word packs the two bits of the first frame into bits 7:6 and those of the fourth frame into bits 1:0. Within each pair the first bit goes high in plain mode and low in HDLC mode. A one-cycle ready pulse follows the last signalling bit of the fourth frame.
- R8: Both transmit words are captured at the frame sync that opens a group, and the load output is high in exactly that cycle. Changing the transmit word inputs later in the group has no effect on the line.
- R9: During bearer slots the transmit line carries the captured word with the same frame packing and mode-dependent bit order as the receive side. During the signalling slot and ignored bits it rests at 1. The line bit is valid in the cycle of the data-clock enable.
- R10: Until the first frame sync, line bits are ignored, no ready or load pulse is raised and the transmit line rests at 1. The first sync opens group frame 0.
- R11: The three mode inputs act independently, so channels in different modes can share one frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle pulse per line bit (data clock sampling edge) |
| fsync | input | 1 | Frame sync, valid with bit_en, marks bit 0 of channel 1 |
| rx_bit | input | 1 | Received line bit |
| b1_hdlc | input | 1 | Channel 1 mode: 0 plain, 1 HDLC |
| b2_hdlc | input | 1 | Channel 2 mode: 0 plain, 1 HDLC |
| d_hdlc | input | 1 | Signalling mode: 0 plain, 1 HDLC |
| b1_tx_word | input | 32 | Channel 1 transmit word |
| b2_tx_word | input | 32 | Channel 2 transmit word |
| tx_bit | output | 1 | Transmitted line bit |
| tx_load | output | 1 | High when the transmit words are captured |
| b1_rx_word | output | 32 | Channel 1 receive word |
| b1_rx_ready | output | 1 | Channel 1 word complete |
| b2_rx_word | output | 32 | Channel 2 receive word |
| b2_rx_ready | output | 1 | Channel 2 word complete |
| d_rx_byte | output | 8 | Signalling receive word |
| d_rx_ready | output | 1 | Signalling word complete |

## Verification
The hardest case to reach from the ports is proving that a transmit word is really latched and not sampled live. The check must tell the difference between a capture at the group-opening sync and a read of the input on each bit. To do this, the stimulus inverts both transmit inputs right after the opening sync and then compares every later bearer bit with the original words. Bit order is pinned down by groups in which only one line bit per end is set, so a reversed byte or a swapped frame lane shows up as a single stray bit. Extra idle bits at the end of each frame, and a stretch of traffic before any sync, test that bits outside a slot are ignored.

// File: rtl/bd_pkg.sv
`timescale 1ns/1ps
package bd_pkg;
  // Which part of the frame the current line bit belongs to.
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_B1   = 2'd1,
    SLOT_B2   = 2'd2,
    SLOT_D    = 2'd3
  } slot_e;
endpackage

// File: rtl/bd_frame_timer.sv
`timescale 1ns/1ps
module bd_frame_timer
  import bd_pkg::*;
#(
  parameter int B_BITS     = 8,
  parameter int D_BITS     = 2,
  parameter int FRAMES     = 4,
  parameter int FRAME_BITS = 18,
  localparam int PW        = $clog2(FRAME_BITS + 1),
  localparam int IW        = $clog2(B_BITS),
  localparam int FW        = $clog2(FRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          fsync,
  output slot_e         slot,
  output logic [IW-1:0] lane_idx,
  output logic [FW-1:0] frm_cur,
  output logic          grp_start,
  output logic          synced
);
  localparam logic [PW-1:0] IDLE_POS = PW'(FRAME_BITS);
  localparam logic [PW-1:0] B2_POS   = PW'(B_BITS);
  localparam logic [PW-1:0] D_POS    = PW'(2 * B_BITS);
  localparam logic [PW-1:0] END_POS  = PW'(2 * B_BITS + D_BITS);
  localparam logic [FW-1:0] LAST_FRM = FW'(FRAMES - 1);

  logic [PW-1:0] pos_q, pos_nxt;
  logic [FW-1:0] frm_q, frm_nxt;
  logic          sync_q, sync_nxt;
  logic          sync_hit;

  assign sync_hit = bit_en && fsync;

  // Next-state: bit position within the frame and frame within the group.
  always_comb begin
    pos_nxt = pos_q;
    if (fsync)
      pos_nxt = '0;
    else if (pos_q != IDLE_POS)
      pos_nxt = pos_q + PW'(1);

    grp_start = sync_hit && (!sync_q || (frm_q == LAST_FRM));
    frm_nxt   = frm_q;
    if (sync_hit)
      frm_nxt = grp_start ? '0 : frm_q + FW'(1);
    sync_nxt  = sync_q || sync_hit;
  end

  // Slot decode for the bit presented in this enable cycle.
  always_comb begin
    slot     = SLOT_IDLE;
    lane_idx = '0;
    if (bit_en) begin
      if (pos_nxt < B2_POS) begin
        slot     = SLOT_B1;
        lane_idx = IW'(pos_nxt);
      end else if (pos_nxt < D_POS) begin
        slot     = SLOT_B2;
        lane_idx = IW'(pos_nxt - B2_POS);
      end else if (pos_nxt < END_POS) begin
        slot     = SLOT_D;
        lane_idx = IW'(pos_nxt - D_POS);
      end
    end
  end

  assign frm_cur = frm_nxt;
  assign synced  = sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= IDLE_POS;
      frm_q  <= '0;
      sync_q <= 1'b0;
    end else if (bit_en) begin
      pos_q  <= pos_nxt;
      frm_q  <= frm_nxt;
      sync_q <= sync_nxt;
    end
  end
endmodule

// File: rtl/bd_lane_rx.sv
`timescale 1ns/1ps
module bd_lane_rx #(
  parameter int LANE_BITS = 8,
  parameter int FRAMES    = 4,
  parameter int IDX_W     = 3,
  parameter int FRM_W     = 2,
  localparam int WORD_W   = LANE_BITS * FRAMES,
  localparam int TW       = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [FRM_W-1:0]  frm,
  input  logic              hdlc,
  input  logic              din,
  output logic [WORD_W-1:0] word,
  output logic              ready
);
  logic [WORD_W-1:0] acc_q, acc_nxt, word_q, word_nxt;
  logic              rdy_q, last;
  logic [FRM_W-1:0]  lane_sel;
  logic [TW-1:0]     target;
  int                bit_sel;

  always_comb begin
    lane_sel = FRM_W'(FRAMES - 1) - frm;
    bit_sel  = hdlc ? int'(idx) : (LANE_BITS - 1 - int'(idx));
    target   = TW'(int'(lane_sel) * LANE_BITS + bit_sel);
    acc_nxt  = acc_q;
    if (en)
      acc_nxt[target] = din;
    last     = en && (idx == IDX_W'(LANE_BITS - 1)) && (frm == FRM_W'(FRAMES - 1));
    word_nxt = last ? acc_nxt : word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      word_q <= '0;
      rdy_q  <= 1'b0;
    end else begin
      rdy_q <= last;
      if (en) acc_q <= acc_nxt;
      if (last) word_q <= word_nxt;
    end
  end

  assign word  = word_q;
  assign ready = rdy_q;
endmodule

// File: rtl/bd_lane_tx.sv
`timescale 1ns/1ps
module bd_lane_tx #(
  parameter int LANE_BITS = 8,
  parameter int FRAMES    = 4,
  parameter int IDX_W     = 3,
  parameter int FRM_W     = 2,
  localparam int WORD_W   = LANE_BITS * FRAMES,
  localparam int TW       = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  input  logic [IDX_W-1:0]  idx,
  input  logic [FRM_W-1:0]  frm,
  input  logic              hdlc,
  output logic              dout
);
  logic [WORD_W-1:0] lat_q, src;
  logic [FRM_W-1:0]  lane_sel;
  logic [TW-1:0]     target;
  int                bit_sel;

  always_comb begin
    src      = load ? word_in : lat_q;
    lane_sel = FRM_W'(FRAMES - 1) - frm;
    bit_sel  = hdlc ? int'(idx) : (LANE_BITS - 1 - int'(idx));
    target   = TW'(int'(lane_sel) * LANE_BITS + bit_sel);
    dout     = src[target];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lat_q <= '0;
    else if (load)
      lat_q <= word_in;
  end
endmodule

// File: rtl/tdm_bd_packer.sv
`timescale 1ns/1ps
module tdm_bd_packer
  import bd_pkg::*;
#(
  parameter int B_BITS     = 8,
  parameter int D_BITS     = 2,
  parameter int FRAMES     = 4,
  parameter int FRAME_BITS = 18,
  localparam int WORD_W    = B_BITS * FRAMES,
  localparam int DWORD_W   = D_BITS * FRAMES,
  localparam int IW        = $clog2(B_BITS),
  localparam int FW        = $clog2(FRAMES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_en,
  input  logic               fsync,
  input  logic               rx_bit,
  input  logic               b1_hdlc,
  input  logic               b2_hdlc,
  input  logic               d_hdlc,
  input  logic [WORD_W-1:0]  b1_tx_word,
  input  logic [WORD_W-1:0]  b2_tx_word,
  output logic               tx_bit,
  output logic               tx_load,
  output logic [WORD_W-1:0]  b1_rx_word,
  output logic               b1_rx_ready,
  output logic [WORD_W-1:0]  b2_rx_word,
  output logic               b2_rx_ready,
  output logic [DWORD_W-1:0] d_rx_byte,
  output logic               d_rx_ready
);
  slot_e         slot;
  logic [IW-1:0] lane_idx;
  logic [FW-1:0] frm_cur;
  logic          grp_start;
  logic          synced;

  logic [1:0]        b_hdlc, b_en, b_tx, b_rdy;
  logic [WORD_W-1:0] b_txw [2];
  logic [WORD_W-1:0] b_rxw [2];

  assign b_hdlc   = {b2_hdlc, b1_hdlc};
  assign b_txw[0] = b1_tx_word;
  assign b_txw[1] = b2_tx_word;

  bd_frame_timer #(
    .B_BITS(B_BITS), .D_BITS(D_BITS), .FRAMES(FRAMES), .FRAME_BITS(FRAME_BITS)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync),
    .slot(slot), .lane_idx(lane_idx), .frm_cur(frm_cur),
    .grp_start(grp_start), .synced(synced)
  );

  // One receive and one transmit lane per bearer channel.
  for (genvar g = 0; g < 2; g++) begin : g_bearer
    localparam slot_e MY_SLOT = (g == 0) ? SLOT_B1 : SLOT_B2;
    assign b_en[g] = (slot == MY_SLOT);

    bd_lane_rx #(
      .LANE_BITS(B_BITS), .FRAMES(FRAMES), .IDX_W(IW), .FRM_W(FW)
    ) u_rx (
      .clk(clk), .rst_n(rst_n), .en(b_en[g]), .idx(lane_idx), .frm(frm_cur),
      .hdlc(b_hdlc[g]), .din(rx_bit), .word(b_rxw[g]), .ready(b_rdy[g])
    );

    bd_lane_tx #(
      .LANE_BITS(B_BITS), .FRAMES(FRAMES), .IDX_W(IW), .FRM_W(FW)
    ) u_tx (
      .clk(clk), .rst_n(rst_n), .load(grp_start), .word_in(b_txw[g]),
      .idx(lane_idx), .frm(frm_cur), .hdlc(b_hdlc[g]), .dout(b_tx[g])
    );
  end

  bd_lane_rx #(
    .LANE_BITS(D_BITS), .FRAMES(FRAMES), .IDX_W(IW), .FRM_W(FW)
  ) u_d_rx (
    .clk(clk), .rst_n(rst_n), .en(slot == SLOT_D), .idx(lane_idx), .frm(frm_cur),
    .hdlc(d_hdlc), .din(rx_bit), .word(d_rx_byte), .ready(d_rx_ready)
  );

  always_comb begin
    tx_bit = 1'b1;
    if (b_en[0])
      tx_bit = b_tx[0];
    else if (b_en[1])
      tx_bit = b_tx[1];
  end

  assign tx_load     = grp_start;
  assign b1_rx_word  = b_rxw[0];
  assign b2_rx_word  = b_rxw[1];
  assign b1_rx_ready = b_rdy[0];
  assign b2_rx_ready = b_rdy[1];
endmodule

// File: rtl/bd_packer_chk.sv
`timescale 1ns/1ps
module bd_packer_chk
  import bd_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_en,
  input logic              fsync,
  input logic              tx_bit,
  input logic              tx_load,
  input logic [WORD_W-1:0] b1_rx_word,
  input logic              b1_rx_ready,
  input logic [WORD_W-1:0] b2_rx_word,
  input logic              b2_rx_ready,
  input logic              d_rx_ready,
  input logic              synced,
  input slot_e             slot
);
  assert_b1_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    b1_rx_ready |=> !b1_rx_ready);
  assert_b2_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    b2_rx_ready |=> !b2_rx_ready);
  assert_b1_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !b1_rx_ready |-> $stable(b1_rx_word));
  assert_b2_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !b2_rx_ready |-> $stable(b2_rx_word));
  assert_d_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    d_rx_ready |=> !d_rx_ready);
  assert_slot_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    b1_rx_ready |-> !b2_rx_ready && !d_rx_ready);
  assert_load_on_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> bit_en && fsync);
  assert_idle_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == SLOT_D || slot == SLOT_IDLE) |-> tx_bit);
  assert_presync_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!synced && !(bit_en && fsync)) |-> tx_bit && !tx_load && !b1_rx_ready && !b2_rx_ready && !d_rx_ready);
endmodule

bind tdm_bd_packer bd_packer_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync),
  .tx_bit(tx_bit), .tx_load(tx_load),
  .b1_rx_word(b1_rx_word), .b1_rx_ready(b1_rx_ready),
  .b2_rx_word(b2_rx_word), .b2_rx_ready(b2_rx_ready),
  .d_rx_ready(d_rx_ready), .synced(synced), .slot(slot)
);

// File: tb/tdm_bd_packer_tb_top.sv
`timescale 1ns/1ps
module tdm_bd_packer_tb_top;
  localparam int LINE_BITS = 20;  // bits driven per frame, two beyond the used slots

  logic        clk, rst_n, bit_en, fsync, rx_bit;
  logic        b1_hdlc, b2_hdlc, d_hdlc;
  logic [31:0] b1_tx_word, b2_tx_word;
  logic        tx_bit, tx_load;
  logic [31:0] b1_rx_word, b2_rx_word;
  logic        b1_rx_ready, b2_rx_ready, d_rx_ready;
  logic [7:0]  d_rx_byte;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int cnt_b1 = 0, cnt_b2 = 0, cnt_d = 0;
  logic [31:0] prev_b1 = '0, prev_b2 = '0;

  tdm_bd_packer dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync), .rx_bit(rx_bit),
    .b1_hdlc(b1_hdlc), .b2_hdlc(b2_hdlc), .d_hdlc(d_hdlc),
    .b1_tx_word(b1_tx_word), .b2_tx_word(b2_tx_word),
    .tx_bit(tx_bit), .tx_load(tx_load),
    .b1_rx_word(b1_rx_word), .b1_rx_ready(b1_rx_ready),
    .b2_rx_word(b2_rx_word), .b2_rx_ready(b2_rx_ready),
    .d_rx_byte(d_rx_byte), .d_rx_ready(d_rx_ready)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (b1_rx_ready) cnt_b1 <= cnt_b1 + 1;
    if (b2_rx_ready) cnt_b2 <= cnt_b2 + 1;
    if (d_rx_ready)  cnt_d  <= cnt_d + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Line bit for lane bit i of frame f, from the packing rules (R3, R4, R5, R7).
  function automatic logic line_bit(input logic [31:0] w, input int f, input int i,
                                    input int lb, input logic hd);
    int pos;
    pos = (3 - f) * lb + (hd ? i : lb - 1 - i);
    return w[pos];
  endfunction

  task automatic drive_bit(input logic fs, input logic din, output logic txo, output logic ldo);
    @(negedge clk);
    bit_en = 1'b1; fsync = fs; rx_bit = din;
    #1;
    txo = tx_bit; ldo = tx_load;
    @(negedge clk);
    bit_en = 1'b0; fsync = 1'b0;
  endtask

  task automatic test_reset();
    rst_n = 1'b0; bit_en = 0; fsync = 0; rx_bit = 0;
    b1_hdlc = 0; b2_hdlc = 0; d_hdlc = 0; b1_tx_word = '0; b2_tx_word = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(b1_rx_word == 0 && b2_rx_word == 0 && d_rx_byte == 0, "R1 words zero",
        b1_rx_word | b2_rx_word | 32'(d_rx_byte), 32'h0);
    chk(!b1_rx_ready && !b2_rx_ready && !d_rx_ready && !tx_load && tx_bit, "R1 strobes/line",
        {27'b0, b1_rx_ready, b2_rx_ready, d_rx_ready, tx_load, tx_bit}, 32'h1);
  endtask

  task automatic test_presync();
    int c1, c2, cd, bad_tx;
    logic txo, ldo;
    c1 = cnt_b1; c2 = cnt_b2; cd = cnt_d; bad_tx = 0;
    b1_tx_word = 32'h0000_0000; b2_tx_word = 32'h0000_0000;
    for (int k = 0; k < 45; k++) begin
      drive_bit(1'b0, logic'(k % 3 == 0), txo, ldo);
      if (!txo || ldo) bad_tx++;
    end
    chk(bad_tx == 0, "R10 line idle before sync", 32'(bad_tx), 32'h0);
    chk(cnt_b1 == c1 && cnt_b2 == c2 && cnt_d == cd, "R10 no ready before sync",
        32'(cnt_b1 + cnt_b2 + cnt_d - c1 - c2 - cd), 32'h0);
    chk(b1_rx_word == 0 && d_rx_byte == 0, "R10 words untouched", b1_rx_word, 32'h0);
  endtask

  task automatic run_group(input logic [31:0] w1, input logic [31:0] w2, input logic [7:0] wd,
                           input logic h1, input logic h2, input logic hd,
                           input logic [31:0] t1, input logic [31:0] t2, input string nm);
    int c1, c2, cd, tx_err, idle_err;
    logic din, txo, ldo, ex;
    c1 = cnt_b1; c2 = cnt_b2; cd = cnt_d; tx_err = 0; idle_err = 0;
    b1_hdlc = h1; b2_hdlc = h2; d_hdlc = hd;
    b1_tx_word = t1; b2_tx_word = t2;
    for (int f = 0; f < 4; f++) begin
      for (int p = 0; p < LINE_BITS; p++) begin
        if (p < 8)       din = line_bit(w1, f, p, 8, h1);
        else if (p < 16) din = line_bit(w2, f, p - 8, 8, h2);
        else if (p < 18) din = line_bit({24'b0, wd}, f, p - 16, 2, hd);
        else             din = logic'(p[0] ^ f[0]);
        drive_bit(logic'(p == 0), din, txo, ldo);
        if (p == 0)
          chk(ldo == (f == 0), {"R8 load strobe ", nm}, 32'(ldo), 32'(f == 0));
        if (f == 0 && p == 0) begin
          // R8: inputs changed after capture must not reach the line
          b1_tx_word = ~t1; b2_tx_word = ~t2;
        end
        if (p < 8)       ex = line_bit(t1, f, p, 8, h1);
        else if (p < 16) ex = line_bit(t2, f, p - 8, 8, h2);
        else             ex = 1'b1;
        if (txo != ex) begin
          if (p < 16) tx_err++; else idle_err++;
        end
        if (f == 1 && p == 10)
          chk(b1_rx_word == prev_b1 && b2_rx_word == prev_b2, {"R6 word held ", nm},
              b1_rx_word, prev_b1);
        if (f == 3 && p == 7) begin
          chk(b1_rx_ready == 1'b1, {"R6 b1 ready timing ", nm}, 32'(b1_rx_ready), 32'h1);
          chk(b1_rx_word == w1, {"R2 R5 b1 word ", nm}, b1_rx_word, w1);
        end
        if (f == 3 && p == 15) begin
          chk(b2_rx_ready == 1'b1, {"R6 b2 ready timing ", nm}, 32'(b2_rx_ready), 32'h1);
          chk(b2_rx_word == w2, {"R2 R5 R11 b2 word ", nm}, b2_rx_word, w2);
        end
        if (f == 3 && p == 17) begin
          chk(d_rx_ready == 1'b1, {"R7 d ready timing ", nm}, 32'(d_rx_ready), 32'h1);
          chk(d_rx_byte == wd, {"R7 d word ", nm}, 32'(d_rx_byte), 32'(wd));
        end
      end
    end
    chk(tx_err == 0, {"R9 R8 bearer line bits ", nm}, 32'(tx_err), 32'h0);
    chk(idle_err == 0, {"R9 idle line bits ", nm}, 32'(idle_err), 32'h0);
    chk(cnt_b1 - c1 == 1 && cnt_b2 - c2 == 1 && cnt_d - cd == 1, {"R6 one pulse each ", nm},
        32'((cnt_b1 - c1) * 100 + (cnt_b2 - c2) * 10 + (cnt_d - cd)), 32'd111);
    prev_b1 = w1; prev_b2 = w2;
  endtask

  // Only the first line bit of frame 0 and the last of frame 3 are set on channel 1.
  task automatic probe_order(input logic hd, input logic [31:0] exp_w, input string tag);
    logic txo, ldo, din;
    b1_hdlc = hd; b2_hdlc = 0; d_hdlc = 0;
    for (int f = 0; f < 4; f++) begin
      for (int p = 0; p < 18; p++) begin
        din = logic'((f == 0 && p == 0) || (f == 3 && p == 7));
        drive_bit(logic'(p == 0), din, txo, ldo);
        if (f == 3 && p == 7)
          chk(b1_rx_word == exp_w && b1_rx_ready, {tag, " R5 probe word"}, b1_rx_word, exp_w);
      end
    end
    chk(b2_rx_word == 0 && d_rx_byte == 0, {tag, " R2 probe other lanes"},
        b2_rx_word | 32'(d_rx_byte), 32'h0);
    prev_b1 = exp_w; prev_b2 = '0;
  endtask

  initial begin
    test_reset();
    test_presync();
    run_group(32'hA1B2_C3D4, 32'h0F1E_2D3C, 8'h9C, 1'b0, 1'b0, 1'b0,
              32'h5A3C_96E1, 32'hC0DE_1234, "plain");
    run_group(32'h1357_9BDF, 32'hF00D_BEEF, 8'h4B, 1'b1, 1'b1, 1'b1,
              32'h8421_7E18, 32'h0123_4567, "hdlc");
    run_group(32'h6C39_E2A5, 32'h7F80_01FE, 8'hD2, 1'b1, 1'b0, 1'b1,
              32'h3355_AACC, 32'hE7C3_8118, "mixed R11");
    probe_order(1'b0, 32'h8000_0001, "R3 plain");
    probe_order(1'b1, 32'h0100_0080, "R4 hdlc");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=%h expected=%h", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule